// File: doc/BRIEF.md
# Tiled View Address Generator

This unit converts a pixel coordinate inside a two-dimensional tiled container into a 32-bit address in tiled space. A request carries a 2-bit pixel format, a 3-bit view code, and X and Y coordinates. The unit mirrors either axis by XOR with the axis mask and can swap the two axes. It packs the coordinate fields into an offset and scales the offset by the format's unused-bit budget. The format and view tags go into the top bits of the address.

The same request also yields the line stride for that format and view. Coordinates beyond the usable range set an error flag and give a zero address. Requests enter through a valid/ready handshake. The result is registered and appears one cycle after acceptance. The result is held while the consumer stalls.

Top module: `tiled_addr_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge (`req_valid && req_ready`) makes `rsp_valid` high after that edge, carrying that request's result.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rsp_addr`, `rsp_err` and `rsp_stride` stay unchanged and `rsp_valid` stays high.
- R4: For an in-range request, address bits [31:29] hold the view code and bits [28:27] hold the format code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page mode).
- R5: Each format drops low bits from the two axes (x_drop, y_drop): 8-bit (0,0), 16-bit (0,1), 32-bit (1,1), page mode (SLOT_XB, SLOT_YB), default (6,6). The usable X bits are xb = CONT_XB - x_drop and the usable Y bits are yb = CONT_YB - y_drop, with defaults CONT_XB = 14 and CONT_YB = 13.
- R6: With view bit 2 clear, the offset is (y << xb) + x. It is shifted left by x_drop + y_drop and placed in bits [26:0].
- R7: View bit 0 set replaces X with X XOR (2^xb - 1). View bit 1 set replaces Y with Y XOR (2^yb - 1). Both are applied before the offset is formed.
- R8: With view bit 2 set, the offset is (x << yb) + y, and is then shifted as in R6.
- R9: If X > 2^xb - 1 or Y > 2^yb - 1, `rsp_err` is 1 and `rsp_addr` is 0. Otherwise `rsp_err` is 0.
- R10: `rsp_stride` is 1 << (CONT_YB + x_drop) when view bit 2 is set, and 1 << (CONT_XB + y_drop) otherwise. It is produced even when R9 flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_fmt | input | 2 | Pixel format code |
| req_view | input | 3 | View code: bit0 X-invert, bit1 Y-invert, bit2 axis swap |
| req_x | input | CONT_XB | X coordinate |
| req_y | input | CONT_YB | Y coordinate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Tiled-space address |
| rsp_err | output | 1 | Coordinate out of range |
| rsp_stride | output | 32 | Line stride in bytes |

## Verification
Two things can happen in the same response: a range error and a stride. The stride must still follow the view and format, while the address is forced to zero. The bench provokes this with coordinates one above the mask of each format, in both swapped and unswapped views, and compares the flag, the zero address and the stride against its own model. A second overlap is a new request that arrives while an earlier result is stalled. The bench checks that the new request is refused, that the held result does not move, and that the new request is served once the stall lifts.

// File: rtl/tva_pkg.sv
package tva_pkg;
  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tva_fmt_e;

  typedef struct packed {
    logic swap;
    logic inv_y;
    logic inv_x;
  } tva_view_t;

  localparam int ADDR_W   = 32;
  localparam int OFFSET_W = 27;
endpackage

// File: rtl/tva_shift_lut.sv
module tva_shift_lut #(
  parameter int SLOT_XB = 6,
  parameter int SLOT_YB = 6,
  parameter int SHW     = 3
) (
  input  logic [1:0]     fmt,
  output logic [SHW-1:0] x_drop,
  output logic [SHW-1:0] y_drop
);
  import tva_pkg::*;

  always_comb begin
    unique case (tva_fmt_e'(fmt))
      FMT_B8:   begin x_drop = '0;            y_drop = '0;            end
      FMT_B16:  begin x_drop = '0;            y_drop = SHW'(1);       end
      FMT_B32:  begin x_drop = SHW'(1);       y_drop = SHW'(1);       end
      default:  begin x_drop = SHW'(SLOT_XB); y_drop = SHW'(SLOT_YB); end
    endcase
  end
endmodule

// File: rtl/tva_mapper.sv
module tva_mapper #(
  parameter int CONT_XB = 14,
  parameter int CONT_YB = 13,
  parameter int SHW     = 3
) (
  input  logic [1:0]         fmt,
  input  logic [2:0]         view,
  input  logic [CONT_XB-1:0] x,
  input  logic [CONT_YB-1:0] y,
  input  logic [SHW-1:0]     x_drop,
  input  logic [SHW-1:0]     y_drop,
  output logic [31:0]        addr,
  output logic               err
);
  import tva_pkg::*;

  localparam int OFF_W = CONT_XB + CONT_YB;
  localparam int BW    = $clog2(OFF_W + 1);

  tva_view_t            v;
  logic [CONT_XB-1:0]   x_mask, x_m;
  logic [CONT_YB-1:0]   y_mask, y_m;
  logic [BW-1:0]        x_bits, y_bits, align;
  logic [OFF_W-1:0]     ext_x, ext_y, off_row, off_col, off;

  assign v      = tva_view_t'(view);
  assign x_mask = {CONT_XB{1'b1}} >> x_drop;
  assign y_mask = {CONT_YB{1'b1}} >> y_drop;
  assign x_bits = BW'(CONT_XB) - BW'(x_drop);
  assign y_bits = BW'(CONT_YB) - BW'(y_drop);
  assign align  = BW'(x_drop) + BW'(y_drop);

  assign err = (x > x_mask) || (y > y_mask);

  assign x_m = v.inv_x ? (x ^ x_mask) : x;
  assign y_m = v.inv_y ? (y ^ y_mask) : y;

  assign ext_x   = OFF_W'(x_m);
  assign ext_y   = OFF_W'(y_m);
  assign off_row = (ext_y << x_bits) | ext_x;
  assign off_col = (ext_x << y_bits) | ext_y;
  assign off     = (v.swap ? off_col : off_row) << align;

  assign addr = err ? '0 : {view, fmt, OFFSET_W'(off)};
endmodule

// File: rtl/tva_stride.sv
module tva_stride #(
  parameter int CONT_XB = 14,
  parameter int CONT_YB = 13,
  parameter int SHW     = 3
) (
  input  logic           swap,
  input  logic [SHW-1:0] x_drop,
  input  logic [SHW-1:0] y_drop,
  output logic [31:0]    stride
);
  logic [5:0] amount;

  assign amount = swap ? (6'(CONT_YB) + 6'(x_drop))
                       : (6'(CONT_XB) + 6'(y_drop));
  assign stride = 32'd1 << amount;
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen #(
  parameter int CONT_XB = 14,
  parameter int CONT_YB = 13,
  parameter int SLOT_XB = 6,
  parameter int SLOT_YB = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_fmt,
  input  logic [2:0]         req_view,
  input  logic [CONT_XB-1:0] req_x,
  input  logic [CONT_YB-1:0] req_y,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_addr,
  output logic               rsp_err,
  output logic [31:0]        rsp_stride
);
  localparam int MAXS = (SLOT_XB > SLOT_YB) ? SLOT_XB : SLOT_YB;
  localparam int SHW  = $clog2(MAXS + 2);

  logic [SHW-1:0] x_drop, y_drop;
  logic [31:0]    addr_c, stride_c;
  logic           err_c;
  logic           accept;

  tva_shift_lut #(.SLOT_XB(SLOT_XB), .SLOT_YB(SLOT_YB), .SHW(SHW)) u_lut (
    .fmt(req_fmt), .x_drop(x_drop), .y_drop(y_drop)
  );

  tva_mapper #(.CONT_XB(CONT_XB), .CONT_YB(CONT_YB), .SHW(SHW)) u_map (
    .fmt(req_fmt), .view(req_view), .x(req_x), .y(req_y),
    .x_drop(x_drop), .y_drop(y_drop), .addr(addr_c), .err(err_c)
  );

  tva_stride #(.CONT_XB(CONT_XB), .CONT_YB(CONT_YB), .SHW(SHW)) u_str (
    .swap(req_view[2]), .x_drop(x_drop), .y_drop(y_drop), .stride(stride_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst)            rsp_valid <= 1'b0;
    else if (req_ready) rsp_valid <= req_valid;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rsp_addr   <= addr_c;
      rsp_err    <= err_c;
      rsp_stride <= stride_c;
    end
  end

  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr)
                                   && $stable(rsp_err) && $stable(rsp_stride)));

  // R4
  fmt_tag_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (rsp_err || rsp_addr[28:27] == $past(req_fmt)));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_addr == 32'd0));

  // R10
  stride_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones(rsp_stride) == 1));
endmodule

// File: tb/sim_tiled_addr_gen.sv
`timescale 1ns/1ps
module sim_tiled_addr_gen;
  localparam int XB = 14;
  localparam int YB = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_fmt = '0;
  logic [2:0]    req_view = '0;
  logic [XB-1:0] req_x = '0;
  logic [YB-1:0] req_y = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [31:0]   rsp_addr;
  logic          rsp_err;
  logic [31:0]   rsp_stride;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tiled_addr_gen u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fmt(req_fmt), .req_view(req_view), .req_x(req_x), .req_y(req_y),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_err(rsp_err), .rsp_stride(rsp_stride)
  );

  function automatic int drop_x(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 0; 2'd2: return 1; default: return 6; endcase
  endfunction
  function automatic int drop_y(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 1; 2'd2: return 1; default: return 6; endcase
  endfunction

  function automatic logic [31:0] exp_addr(input logic [1:0] f, input logic [2:0] o,
                                           input int x, input int y);
    int xb = XB - drop_x(f);
    int yb = YB - drop_y(f);
    int xm = (1 << xb) - 1;
    int ym = (1 << yb) - 1;
    int xi, yi;
    longint off;
    if (x > xm || y > ym) return 32'd0;
    xi = o[0] ? (x ^ xm) : x;
    yi = o[1] ? (y ^ ym) : y;
    off = o[2] ? ((longint'(xi) << yb) + yi) : ((longint'(yi) << xb) + xi);
    off = off << (drop_x(f) + drop_y(f));
    return {o, f, 27'(off)};
  endfunction

  function automatic logic exp_err(input logic [1:0] f, input int x, input int y);
    return (x > (1 << (XB - drop_x(f))) - 1) || (y > (1 << (YB - drop_y(f))) - 1);
  endfunction

  function automatic logic [31:0] exp_stride(input logic [1:0] f, input logic [2:0] o);
    return o[2] ? (32'd1 << (YB + drop_x(f))) : (32'd1 << (XB + drop_y(f)));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_rsp(input logic [1:0] f, input logic [2:0] o, input int x,
                           input int y, input string req);
    logic [31:0] ea = exp_addr(f, o, x, y);
    logic        ee = exp_err(f, x, y);
    logic [31:0] es = exp_stride(f, o);
    check(rsp_valid === 1'b1, {req, " valid"}, 32'(rsp_valid), 32'd1);
    check(rsp_addr === ea && rsp_err === ee, {req, " addr/err"},
          {rsp_addr[30:0], rsp_err}, {ea[30:0], ee});
    check(rsp_stride === es, {req, " R10 stride"}, rsp_stride, es);
  endtask

  task automatic run_one(input logic [1:0] f, input logic [2:0] o, input int x,
                         input int y, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_fmt = f; req_view = o;
    req_x = XB'(x); req_y = YB'(y); rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(f, o, x, y, req);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 in reset",
          {30'd0, rsp_valid, req_ready}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 after reset",
          {30'd0, rsp_valid, req_ready}, 32'd1);

    // R4 R5 R6 plain mapping per format
    for (int f = 0; f < 4; f++) run_one(2'(f), 3'd0, 5, 3, "R4 R5 R6 plain");
    // R7 mirroring on each axis
    for (int f = 0; f < 4; f++) begin
      run_one(2'(f), 3'd1, 9, 2, "R7 x-invert");
      run_one(2'(f), 3'd2, 9, 2, "R7 y-invert");
      run_one(2'(f), 3'd3, 0, 0, "R7 both");
    end
    // R8 swap with and without mirrors
    for (int f = 0; f < 4; f++)
      for (int o = 4; o < 8; o++) run_one(2'(f), 3'(o), 17, 11, "R8 swap");
    // R9 boundary: exactly mask passes, one above fails, stride still given (R10)
    for (int f = 0; f < 4; f++) begin
      int xm = (1 << (XB - drop_x(f))) - 1;
      int ym = (1 << (YB - drop_y(f))) - 1;
      run_one(2'(f), 3'd0, xm, ym, "R9 at mask");
      if (xm < (1 << XB) - 1) begin
        run_one(2'(f), 3'd0, xm + 1, 0, "R9 R10 x over");
        run_one(2'(f), 3'd4, xm + 1, 0, "R9 R10 x over swap");
      end
      if (ym < (1 << YB) - 1) run_one(2'(f), 3'd6, 0, ym + 1, "R9 R10 y over");
    end

    // R2 R3 backpressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_fmt = 2'd2; req_view = 3'd5;
    req_x = XB'(100); req_y = YB'(40);
    @(negedge clk);
    check_rsp(2'd2, 3'd5, 100, 40, "R2 first");
    check(req_ready === 1'b0, "R2 ready low on stall", 32'(req_ready), 32'd0);
    req_fmt = 2'd1; req_view = 3'd2; req_x = XB'(7); req_y = YB'(8);
    @(negedge clk);
    check_rsp(2'd2, 3'd5, 100, 40, "R3 held");
    @(negedge clk);
    check_rsp(2'd2, 3'd5, 100, 40, "R3 held again");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(2'd1, 3'd2, 7, 8, "R2 after stall");
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2 drains", 32'(rsp_valid), 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] f = 2'($urandom);
      logic [2:0] o = 3'($urandom);
      int xm = (1 << (XB - drop_x(f))) - 1;
      int ym = (1 << (YB - drop_y(f))) - 1;
      int x = ($urandom % 4 != 0) ? int'($urandom % (xm + 1)) : int'($urandom % (1 << XB));
      int y = ($urandom % 4 != 0) ? int'($urandom % (ym + 1)) : int'($urandom % (1 << YB));
      run_one(f, o, x, y, "R4 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule